// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Generator

This block drives the active-high reset of a microcontroller system from three sources. The first is a watchdog whose period is picked by a 2-bit code. The second is a digital undervoltage flag, taken from an external comparator that trips at 4.5 V. The third is a power-good indication. The watchdog is serviced by a falling edge on the system's chip-select line, so firmware keeps it alive by simply toggling that select. When the watchdog expires, the block issues a reset pulse of fixed length. A supply fault or a power-up holds reset for as long as the fault lasts, and the same fixed pulse length follows once it clears.

All real-time intervals are counted in milliseconds from a shared prescaler. The prescaler's division ratio defaults to the clock frequency divided by 1000, and it can be overridden to shorten intervals in simulation. The watchdog is cleared and held while reset is asserted, and it starts a full period when reset releases. Asynchronous inputs pass through two-flop synchronizers before use.

Top module: `wdt_supervisor`

## Requirements
- R1: With no service, the reset output rises a full period after the watchdog was last restarted. The period is 1400 ms for select code 2'b00, 600 ms for 2'b01 and 200 ms for 2'b10, with one millisecond equal to TICK_DIV clock cycles.
- R2: Select code 2'b11 disables the watchdog, so it never raises the reset output.
- R3: A watchdog expiry drives the reset output high for exactly PULSE_MS (200) milliseconds, after which it returns low.
- R4: A high-to-low transition on cs_n restarts the watchdog. A low-to-high transition or a steady level on cs_n does not restart it.
- R5: While vlow is 1, the reset output is high. It stays high for PULSE_MS milliseconds after vlow returns to 0.
- R6: While pwr_ok is 0, the reset output is high. It stays high for PULSE_MS milliseconds after pwr_ok returns to 1.
- R7: While rst_n is low, the reset output is high. After rst_n is released, the reset output stays high for PULSE_MS milliseconds (power-on pulse).
- R8: The watchdog counter is held at zero while the reset output is high, and it counts a full period from the cycle in which reset releases.
- R9: A change of the select code restarts the watchdog, which then runs the period of the new code.
- R10: cs_n, vlow and pwr_ok each pass through a two-flop synchronizer. A cs_n falling edge yields a service pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| tmo_sel | input | 2 | Timeout select code (00 long, 01 mid, 10 short, 11 off) |
| cs_n | input | 1 | Chip-select line; its falling edge services the watchdog |
| vlow | input | 1 | Undervoltage flag from the supply comparator, 1 = low supply |
| pwr_ok | input | 1 | Power-good indication, 0 during power-up and power-down |
| rst_out | output | 1 | Active-high system reset |

## Verification
A wrong millisecond count or a wrong period lookup moves the rising edge of rst_out. An error of one millisecond shifts that edge by TICK_DIV cycles, and the shift shows one full period after the last service. A counter that is not cleared while reset is active shows up as an early second reset, in the very first period after release. A broken pulse-stretch counter makes rst_out release early or late, visible PULSE_MS after the trigger. A broken service-edge or synchronizer path either lets a period lapse despite service, or lets a rising edge of cs_n suppress the reset.

// File: rtl/wdt_pkg.sv
// Package: shared types of the reset supervisor.
// Assumes: 2-bit timeout select code supplied by the system integrator.
package wdt_pkg;

    // Timeout select codes; the numeric values are decoded by wdt_timer.
    typedef enum logic [1:0] {
        SEL_LONG  = 2'b00,
        SEL_MID   = 2'b01,
        SEL_SHORT = 2'b10,
        SEL_OFF   = 2'b11
    } tmo_sel_e;

    // Bit width needed to hold values 0..val.
    function automatic int width_for(input int val);
        return (val > 1) ? $clog2(val + 1) : 1;
    endfunction

endpackage

// File: rtl/wdt_sync_bit.sv
// Module: wdt_sync_bit
// Multi-flop synchronizer for a single asynchronous input.
// Assumes: input is a level that stays stable for several clock cycles.
module wdt_sync_bit #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Purpose: shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/wdt_kick_detect.sv
// Module: wdt_kick_detect
// Synchronizes the chip-select line and emits a one-cycle service pulse
// on each high-to-low transition of the synchronized signal.
// Assumes: chip select idles high after reset.
module wdt_kick_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic kick
);
    logic cs_sync;
    logic cs_prev;

    wdt_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cs_n),
        .dout  (cs_sync)
    );

    // Purpose: remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev <= 1'b1;
        end else begin
            cs_prev <= cs_sync;
        end
    end

    assign kick = cs_prev & ~cs_sync;

    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick); // R10

endmodule

// File: rtl/wdt_ms_tick.sv
// Module: wdt_ms_tick
// Millisecond prescaler: pulses tick once every DIV cycles; clr restarts
// the phase so an interval measured from clr is exact.
// Assumes: DIV >= 2.
module wdt_ms_tick #(
    parameter int DIV = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = wdt_pkg::width_for(DIV - 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    // Purpose: count clock cycles within one millisecond.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST) && !clr;

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST); // R1

endmodule

// File: rtl/wdt_timer.sv
// Module: wdt_timer
// Programmable watchdog counter in milliseconds. It restarts on a service
// pulse, on a select-code change and while hold is high; the disabled code
// keeps it cleared. It emits a one-cycle expire pulse when the period lapses.
// Assumes: hold is the block's own reset output (counter frozen during reset).
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int DIV      = 50_000,
    parameter int LONG_MS  = 1400,
    parameter int MID_MS   = 600,
    parameter int SHORT_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  tmo_sel_e   sel,
    input  logic       kick,
    input  logic       hold,
    output logic       expire
);
    localparam int MAX_A  = (LONG_MS > MID_MS) ? LONG_MS : MID_MS;
    localparam int MAX_MS = (MAX_A > SHORT_MS) ? MAX_A : SHORT_MS;
    localparam int MSW    = width_for(MAX_MS);

    tmo_sel_e       sel_q;
    logic [MSW-1:0] ms_cnt;
    logic [MSW-1:0] lim;
    logic           restart;
    logic           tick;

    // Purpose: decode the select code into a millisecond limit.
    always_comb begin
        unique case (sel_q)
            SEL_LONG:  lim = MSW'(LONG_MS);
            SEL_MID:   lim = MSW'(MID_MS);
            SEL_SHORT: lim = MSW'(SHORT_MS);
            default:   lim = MSW'(MAX_MS);
        endcase
    end

    assign restart = kick || hold || (sel != sel_q) || (sel_q == SEL_OFF);

    wdt_ms_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (tick)
    );

    // Purpose: register the select code so a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_LONG;
        end else begin
            sel_q <= sel;
        end
    end

    // Purpose: count elapsed milliseconds since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ms_cnt <= '0;
        end else if (tick) begin
            if (ms_cnt == lim - 1'b1) begin
                ms_cnt <= '0;
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end

    assign expire = tick && (ms_cnt == lim - 1'b1);

    AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_OFF) |-> !expire); // R2
    AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (ms_cnt == '0)); // R8
    AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != sel_q) |=> (ms_cnt == '0)); // R9
    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt <= MSW'(MAX_MS)); // R1

endmodule

// File: rtl/wdt_stretch.sv
// Module: wdt_stretch
// Reset pulse former: a hold request keeps the output high and reloads the
// pulse length; an expire trigger loads it. The output falls PULSE_MS
// milliseconds after the last load. Block reset loads it (power-on pulse).
// Assumes: trigger inputs are synchronous to clk.
module wdt_stretch #(
    parameter int DIV      = 50_000,
    parameter int PULSE_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic pulse_req,
    output logic rst_out
);
    localparam int LW = wdt_pkg::width_for(PULSE_MS);
    localparam logic [LW-1:0] FULL = LW'(PULSE_MS);

    logic [LW-1:0] left_ms;
    logic          load;
    logic          tick;

    assign load = hold_req || pulse_req;

    wdt_ms_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .tick  (tick)
    );

    // Purpose: count down the remaining reset time in milliseconds.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            left_ms <= FULL;
        end else if (tick && (left_ms != '0)) begin
            left_ms <= left_ms - 1'b1;
        end
    end

    assign rst_out = (left_ms != '0);

    AST_HOLD_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> rst_out); // R5
    AST_EXPIRE_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req |=> rst_out); // R3
    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        left_ms <= FULL); // R3

endmodule

// File: rtl/wdt_supervisor.sv
// Module: wdt_supervisor (top)
// Reset supervisor: watchdog serviced by chip-select falling edges, plus
// undervoltage and power-good sources, merged into one active-high reset.
// Assumes: vlow and pwr_ok are digital levels from external analog circuits.
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int TICK_DIV    = CLK_HZ / 1000,
    parameter int LONG_MS     = 1400,
    parameter int MID_MS      = 600,
    parameter int SHORT_MS    = 200,
    parameter int PULSE_MS    = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tmo_sel,
    input  logic       cs_n,
    input  logic       vlow,
    input  logic       pwr_ok,
    output logic       rst_out
);
    logic kick;
    logic vlow_s;
    logic pwr_ok_s;
    logic supply_hold;
    logic expire;

    wdt_kick_detect #(.SYNC_STAGES(SYNC_STAGES)) u_kick (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .kick  (kick)
    );

    wdt_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vlow_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (vlow),
        .dout  (vlow_s)
    );

    wdt_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pwr_ok),
        .dout  (pwr_ok_s)
    );

    assign supply_hold = vlow_s || !pwr_ok_s;

    wdt_timer #(
        .DIV      (TICK_DIV),
        .LONG_MS  (LONG_MS),
        .MID_MS   (MID_MS),
        .SHORT_MS (SHORT_MS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (tmo_sel_e'(tmo_sel)),
        .kick   (kick),
        .hold   (rst_out),
        .expire (expire)
    );

    wdt_stretch #(
        .DIV      (TICK_DIV),
        .PULSE_MS (PULSE_MS)
    ) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (supply_hold),
        .pulse_req (expire),
        .rst_out   (rst_out)
    );

    AST_NO_EXPIRE_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> !expire); // R8
    AST_SUPPLY_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (vlow_s || !pwr_ok_s) |=> rst_out); // R6

endmodule

// File: tb/sim_wdt_supervisor.sv
// Directed bench for wdt_supervisor; each task drives one scenario and
// checks rst_out at cycle offsets derived from the requirements.
module sim_wdt_supervisor;
    localparam int D = 8;     // cycles per millisecond in this bench
    localparam int P = 200;   // reset pulse length in ms

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tmo_sel = 2'b10;
    logic       cs_n = 1'b1;
    logic       vlow = 1'b0;
    logic       pwr_ok = 1'b1;
    logic       rst_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_supervisor #(.TICK_DIV(D)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmo_sel (tmo_sel),
        .cs_n    (cs_n),
        .vlow    (vlow),
        .pwr_ok  (pwr_ok),
        .rst_out (rst_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_rst(input int n, input logic exp, input string tag);
        repeat (n) @(negedge clk);
        chk(rst_out === exp, tag, int'(rst_out), int'(exp));
    endtask

    task automatic wait_low();
        int k = 0;
        while (rst_out !== 1'b0 && k < 40000) begin
            @(negedge clk);
            k++;
        end
    endtask

    // Falling then rising edge on cs_n; returns two cycles after the fall.
    task automatic kick();
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(rst_out === 1'b1, "R7 high during rst_n", int'(rst_out), 1);
        rst_n = 1'b1;
        expect_rst(P * D - 8, 1'b1, "R7 power-on pulse held");
        expect_rst(20, 1'b0, "R7 power-on pulse released");
    endtask

    task automatic t_period(input logic [1:0] sel, input int lms);
        tmo_sel = sel;
        wait_low();
        kick();
        expect_rst(lms * D - 6, 1'b0, "R1 low before period");
        expect_rst(12, 1'b1, "R1 high after period");
        expect_rst(P * D - 16, 1'b1, "R3 pulse still high");
        expect_rst(24, 1'b0, "R3 pulse released");
        expect_rst(lms * D - 20, 1'b0, "R8 low before rerun");
        expect_rst(14, 1'b1, "R8 full period after release");
    endtask

    task automatic t_off();
        int hi = 0;
        tmo_sel = 2'b11;
        wait_low();
        repeat (1400 * D + 3000) begin
            @(negedge clk);
            if (rst_out) hi++;
        end
        chk(hi == 0, "R2 disabled code never resets", hi, 0);
    endtask

    task automatic t_kick();
        int hi = 0;
        tmo_sel = 2'b10;
        wait_low();
        kick();
        for (int i = 0; i < 5; i++) begin
            repeat (1200) begin
                @(negedge clk);
                if (rst_out) hi++;
            end
            kick();
        end
        chk(hi == 0, "R4 regular service prevents reset", hi, 0);
        // fall only, then a lone rising edge that must not restart
        @(negedge clk);
        cs_n = 1'b0;
        expect_rst(800, 1'b0, "R4 low after fall");
        cs_n = 1'b1;
        expect_rst(200 * D - 800 - 4, 1'b0, "R4 low before period");
        expect_rst(12, 1'b1, "R4 rising edge does not service");
    endtask

    task automatic t_sel_change();
        tmo_sel = 2'b00;
        wait_low();
        kick();
        expect_rst(998, 1'b0, "R9 low before change");
        tmo_sel = 2'b10;
        expect_rst(200 * D - 6, 1'b0, "R9 low before new period");
        expect_rst(14, 1'b1, "R9 new period from change");
    endtask

    task automatic t_vlow();
        tmo_sel = 2'b10;
        wait_low();
        @(negedge clk);
        vlow = 1'b1;
        expect_rst(5, 1'b1, "R5 asserts on low supply");
        expect_rst(3000, 1'b1, "R5 held during low supply");
        vlow = 1'b0;
        expect_rst(P * D - 8, 1'b1, "R5 stretched after recovery");
        expect_rst(18, 1'b0, "R5 released after stretch");
    endtask

    task automatic t_pwr();
        tmo_sel = 2'b10;
        wait_low();
        @(negedge clk);
        pwr_ok = 1'b0;
        expect_rst(5, 1'b1, "R6 asserts on power down");
        expect_rst(3000, 1'b1, "R6 held while power not good");
        pwr_ok = 1'b1;
        expect_rst(P * D - 8, 1'b1, "R6 stretched after power good");
        expect_rst(18, 1'b0, "R6 released after stretch");
    endtask

    initial begin
        t_reset();
        t_period(2'b10, 200);
        t_period(2'b01, 600);
        t_period(2'b00, 1400);
        t_off();
        t_kick();
        t_sel_change();
        t_vlow();
        t_pwr();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule